// File: doc/BRIEF.md
# Predicated Arithmetic Execute Unit

This block is the arithmetic stage of a 16-bit processor that has 32 general registers. Each cycle it may accept one two-word instruction together with the two source values already read from the register file. If the instruction belongs to the arithmetic group, the block computes an add, subtract, multiply or divide. One clock later it presents a 16-bit result, a destination write enable with its register index, and an optional update of one of two condition flags.

Control bits in the first word set the behaviour of each instruction. They choose signed or unsigned treatment and turn overflow detection on or off. They also choose which of the two flags receives the overflow result and whether the result is bitwise inverted before the write. Register 31 holds the program counter, so a write aimed at it is dropped, but any flag update still happens. An operation code this group does not define raises a halt request and changes nothing. The register file, instruction fetch and predicate gating are handled outside this block.

Top module: `pae_exec_unit`

## Requirements
- R1: An instruction is taken only when `in_valid` is high and first-word bits 11:8 equal 1. Any other group value leaves `res_valid`, `res_we`, `flg_we` and `halt_req` low in the following cycle.
- R2: Operation code 0 (first-word bits 3:0) adds. The result wraps modulo 2^16. The overflow indication is the carry out for unsigned operation, or signed overflow when first-word bit 7 is 1.
- R3: Operation code 1 subtracts B from A, wrapping modulo 2^16. The unsigned overflow indication is 1 exactly when A < B. The signed indication is true signed overflow.
- R4: Operation code 2 multiplies. The result is the low 16 bits of the product. The overflow indication is 1 when the full product does not fit in 16 bits, read as unsigned or as signed (bit 7).
- R5: Operation code 3 divides A by B. Signed division truncates toward zero. For signed -32768 / -1 the result is 0x8000 and the overflow indication is 1. Unsigned division never indicates overflow.
- R6: A zero divisor in operation code 3 suppresses the register write. If checking is enabled, the selected flag is written with 1.
- R7: When first-word bit 6 (check enable) is 0, `flg_we` stays low. When it is 1 and the instruction is legal, `flg_we` is high and `flg_val` carries the overflow indication.
- R8: First-word bit 5 selects the flag. `flg_sel` = 0 means flag A and 1 means flag B.
- R9: When first-word bit 4 is 1, `res_data` is the bitwise inverse of the wrapped result.
- R10: Second word bits 15:11 and 10:6 index sources A and B, and bits 5:1 give the destination, which appears on `res_idx`. When the destination is 31, `res_we` is low, but the flag update still occurs.
- R11: Operation codes 4 to 15 in the group raise `halt_req` for one cycle, with `res_we` and `flg_we` low.
- R12: All outputs are registered, with a latency of exactly one clock from an accepted input. Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| instr_w0 | input | 16 | First instruction word (group, controls, operation) |
| instr_w1 | input | 16 | Second instruction word (register indices) |
| opnd_a | input | 16 | Value of source register A |
| opnd_b | input | 16 | Value of source register B |
| res_valid | output | 1 | An arithmetic-group instruction completed |
| res_we | output | 1 | Destination register write enable |
| res_idx | output | 5 | Destination register index |
| res_data | output | 16 | Result to write |
| flg_we | output | 1 | Condition flag write enable |
| flg_sel | output | 1 | Flag selected: 0 = A, 1 = B |
| flg_val | output | 1 | Value written to the selected flag |
| halt_req | output | 1 | Undefined operation code: halt request |

## Verification
A wrong decode of a control bit shows up one cycle later at the ports. It appears as a wrong `flg_sel`, a missing inversion on `res_data`, or a flag enable where checking was off. Overflow logic that is wrong for one signedness or one operation only shows on `flg_val` when operands sit near the range edges (0x7FFF, 0x8000, 0xFFFF, zero divisor). For that reason the stream mixes those values with directed corner cases. The block holds no state beyond its output register, so every error appears in the cycle that follows its instruction. That is how a behavioural model compared on every clock catches it.

// File: rtl/pae_pkg.sv
package pae_pkg;
    localparam int DATA_W   = 16;
    localparam int IDX_W    = 5;
    localparam int OPC_W    = 4;
    localparam int GRP_W    = 4;
    localparam logic [GRP_W-1:0] GRP_ARITH = 4'd1;
    localparam logic [IDX_W-1:0] PC_IDX    = {IDX_W{1'b1}};

    // first-word field positions
    localparam int W0_GRP_LO = 8;
    localparam int W0_SGN    = 7;
    localparam int W0_CHK    = 6;
    localparam int W0_FSEL   = 5;
    localparam int W0_INV    = 4;
    // second-word field positions
    localparam int W1_SA_LO  = 11;
    localparam int W1_SB_LO  = 6;
    localparam int W1_DST_LO = 1;

    typedef enum logic [1:0] {
        K_ADD = 2'd0,
        K_SUB = 2'd1,
        K_MUL = 2'd2,
        K_DIV = 2'd3
    } arith_kind_e;

    typedef struct packed {
        logic              hit;
        logic              illegal;
        arith_kind_e       kind;
        logic              is_signed;
        logic              check;
        logic              flag_b;
        logic              invert;
        logic [IDX_W-1:0]  src_a;
        logic [IDX_W-1:0]  src_b;
        logic [IDX_W-1:0]  dst;
    } ctrl_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              ovf;
        logic              div_zero;
    } arith_res_t;

    function automatic logic [DATA_W-1:0] magnitude(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] ? (~v + 1'b1) : v;
    endfunction

    function automatic logic fits_signed(input logic [2*DATA_W-1:0] p);
        return (p[2*DATA_W-1:DATA_W-1] == '0) || (p[2*DATA_W-1:DATA_W-1] == '1);
    endfunction
endpackage

// File: rtl/pae_decode.sv
module pae_decode
    import pae_pkg::*;
(
    input  logic              valid,
    input  logic [DATA_W-1:0] w0,
    input  logic [DATA_W-1:0] w1,
    output ctrl_t             ctrl
);
    logic [GRP_W-1:0] grp;
    logic [OPC_W-1:0] opc;

    always_comb begin
        grp            = w0[W0_GRP_LO +: GRP_W];
        opc            = w0[OPC_W-1:0];
        ctrl.hit       = valid && (grp == GRP_ARITH);
        ctrl.illegal   = (opc > OPC_W'(3));
        ctrl.kind      = arith_kind_e'(opc[1:0]);
        ctrl.is_signed = w0[W0_SGN];
        ctrl.check     = w0[W0_CHK];
        ctrl.flag_b    = w0[W0_FSEL];
        ctrl.invert    = w0[W0_INV];
        ctrl.src_a     = w1[W1_SA_LO  +: IDX_W];
        ctrl.src_b     = w1[W1_SB_LO  +: IDX_W];
        ctrl.dst       = w1[W1_DST_LO +: IDX_W];
    end
endmodule

// File: rtl/pae_divider.sv
module pae_divider
    import pae_pkg::*;
(
    input  logic              is_signed,
    input  logic [DATA_W-1:0] num,
    input  logic [DATA_W-1:0] den,
    output logic [DATA_W-1:0] quo,
    output logic              ovf,
    output logic              zero
);
    logic [DATA_W-1:0] n_mag, d_mag, q_mag;
    logic              neg;

    always_comb begin
        zero  = (den == '0);
        n_mag = is_signed ? magnitude(num) : num;
        d_mag = is_signed ? magnitude(den) : den;
        neg   = is_signed && (num[DATA_W-1] ^ den[DATA_W-1]);
        q_mag = zero ? '0 : (n_mag / d_mag);
        quo   = neg ? (~q_mag + 1'b1) : q_mag;
        // only the most negative value divided by minus one leaves the range
        ovf   = is_signed && !zero &&
                (num == {1'b1, {(DATA_W-1){1'b0}}}) && (den == '1);
    end
endmodule

// File: rtl/pae_arith.sv
module pae_arith
    import pae_pkg::*;
(
    input  ctrl_t             ctrl,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output arith_res_t        res
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]     sum_x;
    logic [DATA_W-1:0]   diff;
    logic [2*DATA_W-1:0] prod_u, prod_s;
    logic [DATA_W-1:0]   quo;
    logic                div_ovf, div_zero;
    logic                add_ovf, sub_ovf, mul_ovf;

    pae_divider u_div (
        .is_signed (ctrl.is_signed),
        .num       (a),
        .den       (b),
        .quo       (quo),
        .ovf       (div_ovf),
        .zero      (div_zero)
    );

    always_comb begin
        sum_x  = {1'b0, a} + {1'b0, b};
        diff   = a - b;
        prod_u = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        prod_s = $unsigned($signed({{DATA_W{a[MSB]}}, a}) * $signed({{DATA_W{b[MSB]}}, b}));

        if (ctrl.is_signed) begin
            add_ovf = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
            sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
            mul_ovf = !fits_signed(prod_s);
        end else begin
            add_ovf = sum_x[DATA_W];
            sub_ovf = (a < b);
            mul_ovf = (prod_u[2*DATA_W-1:DATA_W] != '0);
        end

        res.div_zero = 1'b0;
        unique case (ctrl.kind)
            K_ADD: begin res.value = sum_x[DATA_W-1:0]; res.ovf = add_ovf; end
            K_SUB: begin res.value = diff;              res.ovf = sub_ovf; end
            K_MUL: begin
                res.value = ctrl.is_signed ? prod_s[DATA_W-1:0] : prod_u[DATA_W-1:0];
                res.ovf   = mul_ovf;
            end
            default: begin
                res.value    = quo;
                res.ovf      = div_ovf || div_zero;
                res.div_zero = div_zero;
            end
        endcase
    end
endmodule

// File: rtl/pae_exec_unit.sv
module pae_exec_unit
    import pae_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] instr_w0,
    input  logic [DW-1:0] instr_w1,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic          res_valid,
    output logic          res_we,
    output logic [IW-1:0] res_idx,
    output logic [DW-1:0] res_data,
    output logic          flg_we,
    output logic          flg_sel,
    output logic          flg_val,
    output logic          halt_req
);
    ctrl_t      ctrl;
    arith_res_t ares;
    logic       legal;

    pae_decode u_dec (
        .valid (in_valid),
        .w0    (instr_w0),
        .w1    (instr_w1),
        .ctrl  (ctrl)
    );

    pae_arith u_alu (
        .ctrl (ctrl),
        .a    (opnd_a),
        .b    (opnd_b),
        .res  (ares)
    );

    assign legal = ctrl.hit && !ctrl.illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_we    <= 1'b0;
            res_idx   <= '0;
            res_data  <= '0;
            flg_we    <= 1'b0;
            flg_sel   <= 1'b0;
            flg_val   <= 1'b0;
            halt_req  <= 1'b0;
        end else begin
            res_valid <= ctrl.hit;
            res_we    <= legal && !ares.div_zero && (ctrl.dst != PC_IDX);
            res_idx   <= ctrl.dst;
            res_data  <= ares.value ^ {DW{ctrl.invert}};
            flg_we    <= legal && ctrl.check;
            flg_sel   <= ctrl.flag_b;
            flg_val   <= ares.ovf;
            halt_req  <= ctrl.hit && ctrl.illegal;
        end
    end

    AST_GATED_BY_VALID: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!res_we && !flg_we && !halt_req)); // R1

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr_w0[W0_GRP_LO +: GRP_W] == GRP_ARITH) |=> res_valid); // R12

    AST_CHECK_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !instr_w0[W0_CHK]) |=> !flg_we); // R7

    AST_PC_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        res_we |-> (res_idx != PC_IDX)); // R10

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> (!res_we && !flg_we)); // R11

    AST_DIV_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr_w0[3:0] == 4'd3 && opnd_b == '0) |=> !res_we); // R6
endmodule

// File: tb/pae_exec_unit_tb.sv
`timescale 1ns/1ps
module pae_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr_w0 = '0, instr_w1 = '0, opnd_a = '0, opnd_b = '0;
    logic        res_valid, res_we, flg_we, flg_sel, flg_val, halt_req;
    logic [4:0]  res_idx;
    logic [15:0] res_data;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pae_exec_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .instr_w0(instr_w0), .instr_w1(instr_w1),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_valid(res_valid), .res_we(res_we), .res_idx(res_idx),
        .res_data(res_data), .flg_we(flg_we), .flg_sel(flg_sel),
        .flg_val(flg_val), .halt_req(halt_req)
    );

    // expected outputs for the instruction driven in the previous cycle
    logic        e_v, e_we, e_fwe, e_fs, e_fv, e_hl;
    logic [4:0]  e_idx;
    logic [15:0] e_d;
    string       e_tag;
    bit          pend = 0;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model(input logic vld, input logic [15:0] w0, w1, a, b);
        int     op;
        bit     sgn, chk, inv, dz, ovf;
        longint ia, ib, r;
        op  = int'(w0[3:0]);
        sgn = w0[7]; chk = w0[6]; inv = w0[4];
        e_v = vld && (w0[11:8] == 4'd1);
        e_idx = w1[5:1]; e_fs = w0[5];
        e_hl = e_v && (op >= 4);
        ia = sgn ? longint'($signed(a)) : longint'(a);
        ib = sgn ? longint'($signed(b)) : longint'(b);
        dz = (op == 3) && (b == 16'd0);
        case (op)
            0: r = ia + ib;
            1: r = ia - ib;
            2: r = ia * ib;
            default: r = dz ? 0 : ia / ib;
        endcase
        ovf = sgn ? (r < -32768 || r > 32767) : (r < 0 || r > 65535);
        e_d  = inv ? ~r[15:0] : r[15:0];
        e_we = e_v && !e_hl && !dz && (e_idx != 5'd31);
        e_fwe = e_v && !e_hl && chk;
        e_fv = dz ? 1'b1 : ovf;
    endtask

    task automatic compare_pending();
        if (!pend) return;
        check(e_tag, "res_valid", res_valid, e_v);
        check(e_tag, "res_we", res_we, e_we);
        check(e_tag, "flg_we", flg_we, e_fwe);
        check(e_tag, "halt_req", halt_req, e_hl);
        if (e_v) check(e_tag, "res_idx", res_idx, e_idx);
        if (e_we) check(e_tag, "res_data", res_data, e_d);
        if (e_fwe) begin
            check(e_tag, "flg_sel", flg_sel, e_fs);
            check(e_tag, "flg_val", flg_val, e_fv);
        end
    endtask

    // compare previous result at negedge, then drive the next instruction
    task automatic step(input logic vld, input logic [15:0] w0, w1, a, b, input string tag);
        @(negedge clk);
        compare_pending();
        in_valid = vld; instr_w0 = w0; instr_w1 = w1; opnd_a = a; opnd_b = b;
        model(vld, w0, w1, a, b);
        e_tag = tag;
        pend = 1;
    endtask

    function automatic logic [15:0] w0f(input bit sgn, chk, fsel, inv, input int op);
        return {4'h0, 4'h1, sgn, chk, fsel, inv, 4'(op)};
    endfunction

    function automatic logic [15:0] w1f(input int sa, sb, dst);
        return {5'(sa), 5'(sb), 5'(dst), 1'b0};
    endfunction

    function automatic logic [15:0] pick();
        case ($urandom % 6)
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset", "res_valid", res_valid, 0);
        check("R12 reset", "res_we", res_we, 0);
        check("R12 reset", "flg_we", flg_we, 0);
        check("R12 reset", "halt_req", halt_req, 0);
        check("R12 reset", "res_data", res_data, 0);
        rst = 1'b0;

        step(1, w0f(0,0,0,0,0), w1f(0,1,2), 16'd3, 16'd4, "R2 add 3+4");
        step(1, w0f(0,1,0,0,0), w1f(0,1,2), 16'hFFFF, 16'd5, "R2 unsigned carry");
        step(1, w0f(1,1,1,0,0), w1f(0,1,2), 16'h7FFF, 16'd5, "R2 signed ovf flagB R8");
        step(1, w0f(0,1,0,0,1), w1f(0,1,2), 16'd3, 16'd5, "R3 unsigned borrow");
        step(1, w0f(1,1,0,0,1), w1f(0,1,2), 16'd3, 16'd5, "R3 signed no ovf");
        step(1, w0f(1,1,1,0,1), w1f(0,1,3), 16'h8000, 16'd5, "R3 signed ovf");
        step(1, w0f(0,1,0,0,2), w1f(0,1,2), 16'd3, 16'hFFFF, "R4 unsigned mul ovf");
        step(1, w0f(1,1,0,0,2), w1f(0,1,2), 16'd2, 16'h7FFF, "R4 signed mul ovf");
        step(1, w0f(1,1,0,0,2), w1f(0,1,2), 16'hFFFD, 16'd5, "R4 signed mul fits");
        step(1, w0f(1,1,0,0,3), w1f(0,1,2), 16'hFFF9, 16'd2, "R5 signed div trunc");
        step(1, w0f(1,1,1,0,3), w1f(0,1,2), 16'h8000, 16'hFFFF, "R5 min div -1");
        step(1, w0f(0,1,0,0,3), w1f(0,1,2), 16'hFFFF, 16'd7, "R5 unsigned div");
        step(1, w0f(0,1,1,0,3), w1f(0,1,2), 16'd9, 16'd0, "R6 div zero checked");
        step(1, w0f(0,0,0,0,3), w1f(0,1,2), 16'd9, 16'd0, "R6 div zero unchecked");
        step(1, w0f(1,0,0,0,0), w1f(0,1,2), 16'h7FFF, 16'h7FFF, "R7 check off");
        step(1, w0f(0,0,0,1,0), w1f(0,1,2), 16'd3, 16'd4, "R9 invert");
        step(1, w0f(0,1,1,1,1), w1f(0,1,2), 16'd3, 16'd5, "R9 invert with flag");
        step(1, w0f(0,1,0,0,0), w1f(0,1,31), 16'hFFFF, 16'd1, "R10 dest pc");
        step(1, w0f(0,0,0,0,2), w1f(4,9,17), 16'd6, 16'd7, "R10 index");
        step(1, w0f(0,1,0,0,4), w1f(0,1,2), 16'd1, 16'd1, "R11 op4");
        step(1, w0f(0,1,0,0,15), w1f(0,1,2), 16'd1, 16'd1, "R11 op15");
        step(1, 16'h0200, w1f(0,1,2), 16'd1, 16'd1, "R1 other group");
        step(0, w0f(0,1,0,0,0), w1f(0,1,2), 16'hFFFF, 16'd1, "R1 not valid");
        step(0, 16'h0, 16'h0, 16'h0, 16'h0, "R12 idle");

        for (int i = 0; i < 4000; i++) begin
            logic [15:0] w0;
            w0 = 16'($urandom);
            w0[11:8] = ($urandom % 8 == 0) ? 4'($urandom) : 4'd1;
            w0[3:0]  = 4'($urandom % 6);
            step(($urandom % 5) != 0, w0, 16'($urandom), pick(), pick(), "R12 stream");
        end
        step(0, 16'h0, 16'h0, 16'h0, 16'h0, "R12 drain");
        @(negedge clk);
        compare_pending();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        bad++;
        total++;
        $display("FAIL R12 watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule